// File: doc/BRIEF.md
# USB Host Function PCI Status Register

This block holds the 16-bit PCI configuration status word of a USB host controller function. It records four error events in sticky bits, which software clears by writing 1. Two command-register enables decide whether the system-error and parity events are recorded. A received master abort or target abort on a memory access that the function initiated is a host error. Such an abort raises a halt line to the DMA engines. That line stays high until software has cleared both abort bits.

Each error event arrives as a single-cycle pulse. A register write is sampled on the rising clock edge. The read word is combinational and always reflects the current state. One read-only bit follows the raw interrupt level directly.

Top module: `usb_ehc_pci_status`

## Requirements
- R1: After reset, with the raw interrupt low, the read word is 0x0290 and `dma_halt_o` is low.
- R2: Bits 7 and 4 always read 1. Bits 15, 11, 6, 5 and 2:0 always read 0. Bits 10:9 always read the `DEVSEL_TIME` parameter (default 2'b01). Writes never change any of these bits.
- R3: Writing 1 to sticky bit 14, 13, 12 or 8 clears that bit on the next clock edge. Writing 0 leaves the bit unchanged.
- R4: Bit 14 becomes 1 on the clock edge after `serr_o` is high. It cannot set while `cmd_serr_en_i` is 0.
- R5: Bit 13 becomes 1 on the edge after `master_abort_i`. Bit 12 becomes 1 on the edge after `target_abort_i`. Neither depends on any enable.
- R6: `dma_halt_o` is high exactly while bit 13 or bit 12 is set.
- R7: `serr_o` is high in the same cycle that `cmd_serr_en_i` is 1 and any of `int_serr_i`, `master_abort_i` or `target_abort_i` is 1. Otherwise it is low.
- R8: Bit 8 becomes 1 on the edge after `parity_err_i` while `cmd_parity_resp_i` is 1. It is unaffected while that enable is 0.
- R9: Bit 3 equals `irq_raw_i` in the same cycle.
- R10: When a set event and a write of 1 hit the same sticky bit in one cycle, the bit is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data (1 clears a sticky bit) |
| rd_data_o | output | 16 | Current status word |
| cmd_serr_en_i | input | 1 | Command register system-error enable (bit 8) |
| cmd_parity_resp_i | input | 1 | Command register parity response enable (bit 6) |
| master_abort_i | input | 1 | Received master abort pulse |
| target_abort_i | input | 1 | Received target abort pulse |
| parity_err_i | input | 1 | Read completion data parity error pulse |
| int_serr_i | input | 1 | Internal system-error request pulse |
| irq_raw_i | input | 1 | Interrupt level before enable gating |
| dma_halt_o | output | 1 | Host-error halt to the DMA engines |
| serr_o | output | 1 | System-error output |

## Verification
Each event is driven with its enable both off and on. This shows which bits are gated by an enable and which capture unconditionally. Writes of all ones, of zero, and of single bits show that write-1-to-clear acts bit by bit and cannot reach the constant fields. An abort in the same cycle as a clear of its own bit checks that the set takes priority. Clearing the two abort bits one at a time shows that the halt line drops only after the second one is cleared. A long stretch of random pulses, enables and writes is then compared cycle by cycle against a behavioural model.

// File: rtl/pci_sts_pkg.sv
package pci_sts_pkg;
  localparam int STS_W   = 16;
  localparam int N_STICKY = 4;

  // sticky bank index order
  localparam int IDX_PAR  = 0;
  localparam int IDX_TABT = 1;
  localparam int IDX_MABT = 2;
  localparam int IDX_SERR = 3;

  localparam int POS_IRQ = 3;

  function automatic int sticky_pos(input int idx);
    case (idx)
      IDX_PAR:  return 8;
      IDX_TABT: return 12;
      IDX_MABT: return 13;
      default:  return 14;
    endcase
  endfunction

  function automatic logic [STS_W-1:0] const_word(input logic [1:0] devsel);
    logic [STS_W-1:0] w;
    w = '0;
    w[7] = 1'b1;
    w[4] = 1'b1;
    w[10:9] = devsel;
    return w;
  endfunction
endpackage

// File: rtl/sts_event_gate.sv
module sts_event_gate
  import pci_sts_pkg::*;
(
  input  logic                master_abort_i,
  input  logic                target_abort_i,
  input  logic                parity_err_i,
  input  logic                int_serr_i,
  input  logic                serr_en_i,
  input  logic                parity_resp_i,
  output logic                serr_o,
  output logic [N_STICKY-1:0] set_o
);
  logic serr_req;

  assign serr_req = int_serr_i | master_abort_i | target_abort_i;
  assign serr_o   = serr_en_i & serr_req;

  always_comb begin
    set_o           = '0;
    set_o[IDX_PAR]  = parity_err_i & parity_resp_i;
    set_o[IDX_TABT] = target_abort_i;
    set_o[IDX_MABT] = master_abort_i;
    set_o[IDX_SERR] = serr_o;
  end
endmodule

// File: rtl/sts_w1c_bank.sv
module sts_w1c_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;   // set beats clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_ehc_pci_status.sv
module usb_ehc_pci_status
  import pci_sts_pkg::*;
#(
  parameter logic [1:0] DEVSEL_TIME = 2'b01
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [STS_W-1:0] wr_data_i,
  output logic [STS_W-1:0] rd_data_o,
  input  logic             cmd_serr_en_i,
  input  logic             cmd_parity_resp_i,
  input  logic             master_abort_i,
  input  logic             target_abort_i,
  input  logic             parity_err_i,
  input  logic             int_serr_i,
  input  logic             irq_raw_i,
  output logic             dma_halt_o,
  output logic             serr_o
);
  localparam logic [STS_W-1:0] CONST_W = const_word(DEVSEL_TIME);

  logic [N_STICKY-1:0] set_v, clr_v, sticky_q;

  sts_event_gate u_gate (
    .master_abort_i (master_abort_i),
    .target_abort_i (target_abort_i),
    .parity_err_i   (parity_err_i),
    .int_serr_i     (int_serr_i),
    .serr_en_i      (cmd_serr_en_i),
    .parity_resp_i  (cmd_parity_resp_i),
    .serr_o         (serr_o),
    .set_o          (set_v)
  );

  for (genvar i = 0; i < N_STICKY; i++) begin : g_clr
    assign clr_v[i] = wr_en_i & wr_data_i[sticky_pos(i)];
  end

  sts_w1c_bank #(.N(N_STICKY)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .q_o    (sticky_q)
  );

  always_comb begin
    rd_data_o = CONST_W;
    for (int i = 0; i < N_STICKY; i++) rd_data_o[sticky_pos(i)] = sticky_q[i];
    rd_data_o[POS_IRQ] = irq_raw_i;
  end

  assign dma_halt_o = sticky_q[IDX_MABT] | sticky_q[IDX_TABT];
endmodule

// File: rtl/usb_ehc_pci_status_chk.sv
module usb_ehc_pci_status_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic        cmd_serr_en_i,
  input logic        cmd_parity_resp_i,
  input logic        master_abort_i,
  input logic        target_abort_i,
  input logic        parity_err_i,
  input logic        int_serr_i,
  input logic        irq_raw_i,
  input logic        dma_halt_o,
  input logic        serr_o
);
  localparam logic [15:0] FIX_MASK = 16'b1000_1110_1111_0111;

  a_r2_const_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & FIX_MASK) == 16'h0290);

  a_r3_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[13] && !master_abort_i) |=> !rd_data_o[13]);

  a_r4_sse_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[14] && !cmd_serr_en_i) |=> !rd_data_o[14]);

  a_r5_mabt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_abort_i |=> rd_data_o[13]);

  a_r5_tabt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_abort_i |=> rd_data_o[12]);

  a_r6_halt_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_halt_o == (rd_data_o[13] | rd_data_o[12]));

  a_r7_serr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_serr_en_i |-> !serr_o);

  a_r8_par_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[8] && !(parity_err_i && cmd_parity_resp_i)) |=> !rd_data_o[8]);

  a_r9_irq_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[3] == irq_raw_i);

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (target_abort_i && wr_en_i && wr_data_i[12]) |=> rd_data_o[12]);
endmodule

bind usb_ehc_pci_status usb_ehc_pci_status_chk u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .wr_en_i           (wr_en_i),
  .wr_data_i         (wr_data_i),
  .rd_data_o         (rd_data_o),
  .cmd_serr_en_i     (cmd_serr_en_i),
  .cmd_parity_resp_i (cmd_parity_resp_i),
  .master_abort_i    (master_abort_i),
  .target_abort_i    (target_abort_i),
  .parity_err_i      (parity_err_i),
  .int_serr_i        (int_serr_i),
  .irq_raw_i         (irq_raw_i),
  .dma_halt_o        (dma_halt_o),
  .serr_o            (serr_o)
);

// File: tb/usb_ehc_pci_status_test.sv
module usb_ehc_pci_status_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        cmd_serr_en_i = 1'b0, cmd_parity_resp_i = 1'b0;
  logic        master_abort_i = 1'b0, target_abort_i = 1'b0;
  logic        parity_err_i = 1'b0, int_serr_i = 1'b0, irq_raw_i = 1'b0;
  logic        dma_halt_o, serr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model sticky state
  bit m_sse, m_rma, m_rta, m_par;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  usb_ehc_pci_status uut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_serr();
    return cmd_serr_en_i && (int_serr_i || master_abort_i || target_abort_i);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sse <= 0; m_rma <= 0; m_rta <= 0; m_par <= 0;
    end else begin
      m_sse <= m_serr() ? 1'b1 : (wr_en_i && wr_data_i[14]) ? 1'b0 : m_sse;
      m_rma <= master_abort_i ? 1'b1 : (wr_en_i && wr_data_i[13]) ? 1'b0 : m_rma;
      m_rta <= target_abort_i ? 1'b1 : (wr_en_i && wr_data_i[12]) ? 1'b0 : m_rta;
      m_par <= (parity_err_i && cmd_parity_resp_i) ? 1'b1 :
               (wr_en_i && wr_data_i[8]) ? 1'b0 : m_par;
    end
  end

  // per-cycle compare against model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R2 fixed", rd_data_o & 16'h8EF7, 16'h0290);
      chk("R4 bit14", 16'(rd_data_o[14]), 16'(m_sse));
      chk("R5 bit13", 16'(rd_data_o[13]), 16'(m_rma));
      chk("R5 bit12", 16'(rd_data_o[12]), 16'(m_rta));
      chk("R8 bit8", 16'(rd_data_o[8]), 16'(m_par));
      chk("R9 bit3", 16'(rd_data_o[3]), 16'(irq_raw_i));
      chk("R6 halt", 16'(dma_halt_o), 16'(m_rma | m_rta));
      chk("R7 serr", 16'(serr_o), 16'(m_serr()));
    end
  end

  task automatic cyc();
    @(posedge clk_i); #2;
    wr_en_i = 0; wr_data_i = '0;
    master_abort_i = 0; target_abort_i = 0; parity_err_i = 0; int_serr_i = 0;
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en_i = 1; wr_data_i = d; cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    #1 chk("R1 reset word", rd_data_o, 16'h0290);
    chk("R1 reset halt", 16'(dma_halt_o), 16'h0);
    cyc();
    wr(16'hFFFF);
    #1 chk("R2 all-ones write", rd_data_o, 16'h0290);
    irq_raw_i = 1; #1 chk("R9 irq high", rd_data_o, 16'h0298);
    irq_raw_i = 0;
    master_abort_i = 1; #1 chk("R7 no serr when disabled", 16'(serr_o), 16'h0);
    cyc(); #1 chk("R5 master abort", rd_data_o, 16'h2290);
    chk("R6 halt on abort", 16'(dma_halt_o), 16'h1);
    wr(16'h0000); #1 chk("R3 zero write keeps", rd_data_o, 16'h2290);
    wr(16'h2000); #1 chk("R3 one write clears", rd_data_o, 16'h0290);
    chk("R6 halt drops", 16'(dma_halt_o), 16'h0);
    cmd_serr_en_i = 1; target_abort_i = 1;
    #1 chk("R7 serr on abort", 16'(serr_o), 16'h1);
    cyc(); #1 chk("R4 R5 target abort", rd_data_o, 16'h5290);
    wr(16'h5000);
    cmd_serr_en_i = 0; int_serr_i = 1; cyc();
    #1 chk("R4 no set disabled", rd_data_o, 16'h0290);
    cmd_serr_en_i = 1; int_serr_i = 1; cyc();
    #1 chk("R4 internal serr", rd_data_o, 16'h4290);
    wr(16'h4000); cmd_serr_en_i = 0;
    parity_err_i = 1; cyc(); #1 chk("R8 parity disabled", rd_data_o, 16'h0290);
    cmd_parity_resp_i = 1; parity_err_i = 1; cyc();
    #1 chk("R8 parity enabled", rd_data_o, 16'h0390);
    wr(16'h0100);
    master_abort_i = 1; wr(16'h2000);
    #1 chk("R10 set wins", rd_data_o, 16'h2290);
    target_abort_i = 1; cyc();
    wr(16'h2000); #1 chk("R6 halt held by other abort", 16'(dma_halt_o), 16'h1);
    wr(16'h1000); #1 chk("R6 halt released", 16'(dma_halt_o), 16'h0);
    for (int i = 0; i < 400; i++) begin
      cmd_serr_en_i = 1'($urandom);
      cmd_parity_resp_i = 1'($urandom);
      irq_raw_i = 1'($urandom);
      master_abort_i = ($urandom % 6) == 0;
      target_abort_i = ($urandom % 6) == 0;
      parity_err_i = ($urandom % 4) == 0;
      int_serr_i = ($urandom % 5) == 0;
      wr_en_i = ($urandom % 3) == 0;
      wr_data_i = 16'($urandom);
      @(posedge clk_i); #2;
    end
    cyc(); cyc();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule